// File: doc/BRIEF.md
# Shift-Capable Integer ALU

This block is the combinational arithmetic unit of a small single-cycle RISC datapath. Its inputs are the two register-file read values, the 5-bit shift-count field of the instruction word, a 2-bit operation class from the main decoder and the 6-bit function code of register-format instructions. It produces a 32-bit result and a flag that is high when that result is zero. Besides add, subtract, and, or and signed set-less-than, it performs logical left and right shifts. The count for a shift comes either from the instruction field (immediate form) or from the low bits of the first register operand (variable form).

The value that is shifted is always the second register operand. The first register operand only supplies the count for variable shifts. A count selector inside the block picks the count source. A barrel shifter built from one stage per count bit then moves the second operand. The datapath writes the result to the destination register of the instruction.

Top module: `shift_alu`

## Requirements
- R1: With operation class 2'b00 the result is src_a + src_b (modulo 2^32), whatever the function code.
- R2: With operation class 2'b01 the result is src_a - src_b (modulo 2^32), whatever the function code.
- R3: With operation class 2'b10, function code 6'h20 gives src_a + src_b, 6'h22 gives src_a - src_b, 6'h24 gives the bitwise and, and 6'h25 gives the bitwise or.
- R4: With operation class 2'b10 and function code 6'h2A, the result is 1 when src_a is less than src_b as signed two's-complement numbers, and 0 otherwise.
- R5: With operation class 2'b11 and function code 6'h00, the result is src_b shifted left by sa_field, with zeros shifted in at the low end.
- R6: With operation class 2'b11 and function code 6'h02, the result is src_b shifted right by sa_field, with zeros filling the vacated high bits.
- R7: With operation class 2'b11, function code 6'h04 shifts src_b left and 6'h06 shifts it right, each by src_a[4:0]. Bits 31:5 of src_a and the value of sa_field have no effect.
- R8: A shift by a count of 0 returns src_b unchanged. For the immediate forms (6'h00, 6'h02), src_a has no effect on the result.
- R9: zero is 1 exactly when all 32 bits of result are 0.
- R10: Any function code not listed for operation class 2'b10 or 2'b11 gives a result of 0, and zero is then 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 32 | First register read value; it supplies the count for variable shifts |
| src_b | input | 32 | Second register read value; it is the operand that shifts move |
| sa_field | input | 5 | Shift-count field taken from the instruction word |
| op_class | input | 2 | Operation class from the main decoder |
| func | input | 6 | Function code of register-format instructions |
| result | output | 32 | Computed value |
| zero | output | 1 | High when result equals zero |

## Verification
Two things can happen in the same evaluation: the shifter pushes every set bit of src_b out of the word, and the zero flag must then rise. The bench provokes this with directed shifts by 31 of values whose set bits all leave the word, and with variable shifts whose count register has large upper bits that must be masked off. In each case it compares both result and zero against a reference model in the bench. Random vectors over every class and function code, with counts at 0 and 31, add more cases where a shift and the flag act together.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned FUNC_W  = 6;
    localparam int unsigned CLASS_W = 2;

    localparam logic [FUNC_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FUNC_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FUNC_W-1:0] FN_SLLV = 6'h04;
    localparam logic [FUNC_W-1:0] FN_SRLV = 6'h06;
    localparam logic [FUNC_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FUNC_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FUNC_W-1:0] FN_AND  = 6'h24;
    localparam logic [FUNC_W-1:0] FN_OR   = 6'h25;
    localparam logic [FUNC_W-1:0] FN_SLT  = 6'h2A;

    localparam logic [CLASS_W-1:0] CLS_MEM   = 2'b00;
    localparam logic [CLASS_W-1:0] CLS_BRN   = 2'b01;
    localparam logic [CLASS_W-1:0] CLS_RTYPE = 2'b10;
    localparam logic [CLASS_W-1:0] CLS_SHIFT = 2'b11;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_SLT,
        OP_SHIFT,
        OP_NONE
    } alu_op_e;

    typedef struct packed {
        logic right;
        logic var_cnt;
    } shift_ctl_t;

    function automatic logic signed_less(input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b);
        return $signed(a) < $signed(b);
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import shift_alu_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNC_W-1:0]  func,
    output alu_op_e            op,
    output shift_ctl_t         sctl
);
    always_comb begin
        op   = OP_NONE;
        sctl = '0;
        unique case (op_class)
            CLS_MEM: op = OP_ADD;
            CLS_BRN: op = OP_SUB;
            CLS_RTYPE: begin
                case (func)
                    FN_ADD:  op = OP_ADD;
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_SLT:  op = OP_SLT;
                    default: op = OP_NONE;
                endcase
            end
            CLS_SHIFT: begin
                case (func)
                    FN_SLL, FN_SRL, FN_SLLV, FN_SRLV: begin
                        op           = OP_SHIFT;
                        sctl.right   = func[1];
                        sctl.var_cnt = func[2];
                    end
                    default: op = OP_NONE;
                endcase
            end
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/shamt_select.sv
module shamt_select #(
    parameter int unsigned DW = 32,
    localparam int unsigned CW = $clog2(DW)
) (
    input  logic          var_cnt,
    input  logic [CW-1:0] field_cnt,
    input  logic [DW-1:0] reg_cnt,
    output logic [CW-1:0] count
);
    assign count = var_cnt ? reg_cnt[CW-1:0] : field_cnt;
endmodule

// File: rtl/barrel_shift.sv
module barrel_shift #(
    parameter int unsigned DW = 32,
    localparam int unsigned CW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] count,
    input  logic          right,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stage [0:CW];

    assign stage[0] = din;

    for (genvar i = 0; i < CW; i++) begin : g_stage
        localparam int unsigned STEP = 1 << i;
        logic [DW-1:0] moved;
        assign moved        = right ? (stage[i] >> STEP) : (stage[i] << STEP);
        assign stage[i + 1] = count[i] ? moved : stage[i];
    end

    assign dout = stage[CW];

    always_comb begin
        AST_SRL_ZERO_FILL: assert (!(right && count != '0) || dout[DW-1] == 1'b0) else $error("srl fill"); // R6
        AST_SLL_ZERO_FILL: assert (!(!right && count != '0) || dout[0] == 1'b0) else $error("sll fill"); // R5
        AST_SHIFT_KEEPS_ONES: assert ($countones(dout) <= $countones(din)) else $error("ones grew"); // R5
    end
endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import shift_alu_pkg::*;
(
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [4:0]  sa_field,
    input  logic [1:0]  op_class,
    input  logic [5:0]  func,
    output logic [31:0] result,
    output logic        zero
);
    localparam int unsigned CW = $clog2(DATA_W);

    alu_op_e            op;
    shift_ctl_t         sctl;
    logic [CW-1:0]      count;
    logic [DATA_W-1:0]  shifted;

    alu_decode u_dec (
        .op_class (op_class),
        .func     (func),
        .op       (op),
        .sctl     (sctl)
    );

    shamt_select #(.DW(DATA_W)) u_cnt (
        .var_cnt   (sctl.var_cnt),
        .field_cnt (sa_field),
        .reg_cnt   (src_a),
        .count     (count)
    );

    barrel_shift #(.DW(DATA_W)) u_shf (
        .din   (src_b),
        .count (count),
        .right (sctl.right),
        .dout  (shifted)
    );

    always_comb begin
        unique case (op)
            OP_ADD:   result = src_a + src_b;
            OP_SUB:   result = src_a - src_b;
            OP_AND:   result = src_a & src_b;
            OP_OR:    result = src_a | src_b;
            OP_SLT:   result = {{(DATA_W-1){1'b0}}, signed_less(src_a, src_b)};
            OP_SHIFT: result = shifted;
            default:  result = '0;
        endcase
    end

    assign zero = (result == '0);

    always_comb begin
        AST_SHIFT_BY_ZERO: assert (!(op == OP_SHIFT && count == '0) || result == src_b) else $error("noop shift"); // R8
        AST_SLT_IS_BIT: assert (op != OP_SLT || result[DATA_W-1:1] == '0) else $error("slt width"); // R4
        AST_ZERO_FLAG: assert (!zero || $countones(result) == 0) else $error("zero flag"); // R9
        AST_UNKNOWN_FUNC: assert (op != OP_NONE || zero) else $error("unknown func"); // R10
    end
endmodule

// File: tb/shift_alu_test.sv
module shift_alu_test;
    logic        clk = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [4:0]  sa_field = '0;
    logic [1:0]  op_class = '0;
    logic [5:0]  func = '0;
    logic [31:0] result;
    logic        zero;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    shift_alu uut (
        .src_a(src_a), .src_b(src_b), .sa_field(sa_field),
        .op_class(op_class), .func(func), .result(result), .zero(zero)
    );

    function automatic logic [31:0] ref_res(logic [31:0] a, logic [31:0] b,
                                            logic [4:0] sa, logic [1:0] c, logic [5:0] f);
        case (c)
            2'b00: return a + b;
            2'b01: return a - b;
            2'b10: case (f)
                6'h20: return a + b;
                6'h22: return a - b;
                6'h24: return a & b;
                6'h25: return a | b;
                6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                default: return 32'd0;
            endcase
            default: case (f)
                6'h00: return b << sa;
                6'h02: return b >> sa;
                6'h04: return b << a[4:0];
                6'h06: return b >> a[4:0];
                default: return 32'd0;
            endcase
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] c, logic [5:0] f);
        if (c == 2'b00) return "R1";
        if (c == 2'b01) return "R2";
        if (c == 2'b10) begin
            if (f == 6'h2A) return "R4";
            if (f == 6'h20 || f == 6'h22 || f == 6'h24 || f == 6'h25) return "R3";
            return "R10";
        end
        if (f == 6'h00) return "R5";
        if (f == 6'h02) return "R6";
        if (f == 6'h04 || f == 6'h06) return "R7";
        return "R10";
    endfunction

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [4:0] sa,
                         logic [1:0] c, logic [5:0] f, string tag);
        logic [31:0] exp_r;
        @(posedge clk);
        src_a = a; src_b = b; sa_field = sa; op_class = c; func = f;
        @(negedge clk);
        exp_r = ref_res(a, b, sa, c, f);
        n_run++;
        if (result !== exp_r) begin
            n_fail++;
            $display("FAIL %s result actual=%h expected=%h (cls=%b fn=%h)", tag, result, exp_r, c, f);
        end
        n_run++;
        if (zero !== (exp_r == 32'd0)) begin
            n_fail++;
            $display("FAIL R9 zero actual=%b expected=%b (%s)", zero, exp_r == 32'd0, tag);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] fcodes [0:10];
        fcodes = '{6'h00, 6'h02, 6'h04, 6'h06, 6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h01, 6'h3F};
        void'($urandom(32'd2024));

        apply(32'd0, 32'd0, 5'd0, 2'b00, 6'h00, "R1");             // idle inputs
        apply(32'hFFFF_FFFF, 32'd1, 5'd3, 2'b00, 6'h2A, "R1");     // wraps, funct ignored
        apply(32'd5, 32'd7, 5'd0, 2'b01, 6'h25, "R2");             // borrow
        apply(32'h0F0F_00FF, 32'h00FF_0F0F, 5'd0, 2'b10, 6'h24, "R3");
        apply(32'h0F0F_00FF, 32'h00FF_0F0F, 5'd0, 2'b10, 6'h25, "R3");
        apply(32'h8000_0000, 32'd1, 5'd0, 2'b10, 6'h2A, "R4");     // negative < positive
        apply(32'd1, 32'h8000_0000, 5'd0, 2'b10, 6'h2A, "R4");
        apply(32'd9, 32'd9, 5'd0, 2'b10, 6'h2A, "R4");             // equal
        apply(32'hDEAD_BEEF, 32'h8000_0001, 5'd31, 2'b11, 6'h00, "R5"); // rs ignored
        apply(32'h0, 32'h8000_0001, 5'd31, 2'b11, 6'h02, "R6");
        apply(32'h0, 32'hFFFF_FFFF, 5'd16, 2'b11, 6'h02, "R6");
        apply(32'hFFFF_FFE4, 32'h0000_0003, 5'd1, 2'b11, 6'h04, "R7");  // count 4, upper bits masked
        apply(32'h1234_5661, 32'hF000_0000, 5'd7, 2'b11, 6'h06, "R7");  // count 1
        apply(32'hFFFF_FFE0, 32'hCAFE_F00D, 5'd9, 2'b11, 6'h04, "R8");  // variable count 0
        apply(32'h5555_5555, 32'hCAFE_F00D, 5'd0, 2'b11, 6'h02, "R8");  // immediate count 0
        apply(32'h0000_001F, 32'h0000_0002, 5'd0, 2'b11, 6'h04, "R9");  // shifted out -> zero
        apply(32'h0000_0000, 32'h4000_0000, 5'd31, 2'b11, 6'h02, "R9");
        apply(32'h1, 32'h2, 5'd3, 2'b10, 6'h01, "R10");
        apply(32'h1, 32'h2, 5'd3, 2'b11, 6'h20, "R10");

        for (int i = 0; i < 600; i++) begin
            logic [1:0]  c;
            logic [5:0]  f;
            logic [31:0] a, b;
            logic [4:0]  sa;
            c  = 2'($urandom_range(0, 3));
            f  = fcodes[$urandom_range(0, 10)];
            a  = $urandom;
            b  = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
            sa = ($urandom_range(0, 3) == 0) ? 5'(($urandom_range(0, 1)) * 31) : 5'($urandom);
            apply(a, b, sa, c, f, tag_of(c, f));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule